// File: doc/BRIEF.md
# Single-Event-Upset Fault Injector

This block sits in the next-state path of one state register inside a design under test. It can invert one chosen bit of that register exactly once after each reset. A self-checking testbench can then see whether a single bit flip breaks the behaviour the circuit is required to keep. The block receives the register's normal next value, its current value, an arm request and a bit index. It returns the next value, corrupted in one cycle at most, and a sticky flag that records that the one shot has been used.

A small automaton with a pending bit and an occurred bit controls the injection. The automaton starts either idle or already armed, as chosen by an input sampled during reset. From idle, the arm input moves it to armed in any later cycle. One cycle later the flip lands and the automaton settles in done, where it stays until the next reset. Only three states can be reached: idle (pending 0, occurred 0), armed (pending 1, occurred 0) and done (pending 1, occurred 1).

Top module: `seu_flip_injector`

## Requirements
- R1: While reset is held with `start_armed` low, and after reset is released, `upset_done` is 0 and `next_out` equals `next_in`.
- R2: If `start_armed` is 1 during reset, the bit index is taken from `bit_sel` during reset. The flip appears on `next_out` in every reset cycle and in the first cycle after release. The register loads it at the first clock edge with reset released.
- R3: In the idle state, `arm` high at a clock edge captures `bit_sel`. The following cycle is the flip cycle.
- R4: In the flip cycle, with index k below WIDTH, bit k of `next_out` is the inverse of `cur_in[k]`. Every other bit equals `next_in`. When `next_in` equals `cur_in`, exactly one bit differs from `next_in`.
- R5: A change to `bit_sel` after the arm edge has no effect on which bit is flipped.
- R6: An index of WIDTH or more suppresses the flip: `next_out` equals `next_in` in that cycle. The shot is still consumed and `upset_done` still rises.
- R7: `upset_done` rises at the clock edge that ends the flip cycle and stays 1 until the next reset.
- R8: Once done, `arm` pulses are ignored. `next_out` equals `next_in` and `upset_done` stays 1.
- R9: In every cycle other than the flip cycle, `next_out` equals `next_in`.
- R10: A fresh reset returns the block to its initial state, so one new flip can be made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_armed | input | 1 | Initial state chosen at reset: 1 armed, 0 idle |
| arm | input | 1 | Request to arm from idle |
| bit_sel | input | SEL_W | Index of the bit to invert |
| next_in | input | WIDTH | Normal next value of the wrapped register |
| cur_in | input | WIDTH | Current value of the wrapped register |
| next_out | output | WIDTH | Next value to load, corrupted in the flip cycle only |
| upset_done | output | 1 | Sticky flag: the one shot has been used |

## Verification
The bench goes after the moment the index is captured. A design that read `bit_sel` live would flip the wrong bit when the index changes right after arming. It also tests arm pulses after done, where a design that re-arms would inject a second flip. It arms with an out-of-range index, which would corrupt a wrapped or stray bit if not suppressed. With `start_armed` high at reset, a late design would miss the first cycle after release. Comparing against a golden next value in every cycle catches any flip outside the flip cycle.

// File: rtl/seu_flip_injector.sv
module seu_flip_injector #(
  parameter int WIDTH = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_armed,
  input  logic             arm,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic [WIDTH-1:0] next_in,
  input  logic [WIDTH-1:0] cur_in,
  output logic [WIDTH-1:0] next_out,
  output logic             upset_done
);

  logic             pending;
  logic             occurred;
  logic [SEL_W-1:0] hold_sel;

  wire is_idle  = ~pending;
  wire is_armed = pending & ~occurred;
  wire in_range = int'(hold_sel) < WIDTH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= start_armed;
      occurred <= 1'b0;
      hold_sel <= bit_sel;
    end else begin
      if (is_idle && arm) begin
        pending  <= 1'b1;
        hold_sel <= bit_sel;
      end
      if (is_armed) occurred <= 1'b1;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign next_out[i] = (is_armed && in_range && hold_sel == SEL_W'(i)) ? ~cur_in[i] : next_in[i];
  end

  assign upset_done = occurred;

  AST_AT_MOST_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(next_out ^ next_in)); // R4
  AST_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_armed |-> next_out == next_in); // R9
  AST_NO_ILLEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(occurred && !pending)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    upset_done |=> upset_done); // R7
  AST_ARM_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && arm) |=> (pending && !upset_done)); // R3
  AST_SHOT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    is_armed |=> upset_done); // R7
  AST_DONE_IGNORES_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (upset_done && arm) |-> next_out == next_in); // R8

endmodule

// File: tb/seu_flip_injector_test.sv
module seu_flip_injector_test;
  localparam int WIDTH = 8;
  localparam int SEL_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_armed = 1'b0;
  logic             arm = 1'b0;
  logic [SEL_W-1:0] bit_sel = '0;
  logic [WIDTH-1:0] next_in = '0;
  logic [WIDTH-1:0] cur_in = '0;
  logic [WIDTH-1:0] next_out;
  logic             upset_done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  bit m_pend, m_occ;
  int m_idx;

  always #10 clk = ~clk;

  seu_flip_injector #(.WIDTH(WIDTH), .SEL_W(SEL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_armed(start_armed), .arm(arm),
    .bit_sel(bit_sel), .next_in(next_in), .cur_in(cur_in),
    .next_out(next_out), .upset_done(upset_done));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = start_armed;
      m_occ  = 1'b0;
      m_idx  = int'(bit_sel);
    end else if (m_pend && !m_occ) begin
      m_occ = 1'b1;
    end else if (!m_pend && arm) begin
      m_pend = 1'b1;
      m_idx  = int'(bit_sel);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic r, input logic sa, input logic a,
                      input logic [SEL_W-1:0] s, input logic [WIDTH-1:0] dn,
                      input logic [WIDTH-1:0] qc);
    logic [WIDTH-1:0] exp;
    @(negedge clk);
    rst_n = r; start_armed = sa; arm = a; bit_sel = s; next_in = dn; cur_in = qc;
    #1;
    exp = dn;
    if (m_pend && !m_occ && m_idx < WIDTH) exp[m_idx] = ~qc[m_idx];
    check({tag, " next_out"}, 32'(next_out), 32'(exp));
    check({tag, " upset_done"}, 32'(upset_done), 32'(m_occ));
  endtask

  initial begin
    repeat (2) @(posedge clk);
    step("R1 reset idle", 0, 0, 0, 4'd2, 8'h3C, 8'h11);
    step("R1 after reset", 1, 0, 0, 4'd2, 8'h5A, 8'h22);
    check("R1 done low", 32'(upset_done), 32'd0);
    for (int i = 0; i < 4; i++) step("R9 idle quiet", 1, 0, 0, 4'(i), 8'(8'h10 * i + 3), 8'hF0);
    step("R3 arm sel3", 1, 0, 1, 4'd3, 8'h81, 8'h42);
    step("R5 sel moved", 1, 0, 0, 4'd5, 8'h66, 8'h66);
    check("R4 bit3 inverted", 32'(next_out), 32'h6E);
    check("R4 one bit differs", 32'($countones(next_out ^ next_in)), 32'd1);
    step("R7 done rises", 1, 0, 0, 4'd5, 8'h66, 8'h66);
    check("R7 done high", 32'(upset_done), 32'd1);
    for (int i = 0; i < 5; i++) step("R8 arm ignored", 1, 0, 1, 4'(i), 8'(8'h37 + i), 8'(8'h37 + i));
    check("R8 done kept", 32'(upset_done), 32'd1);
    step("R2 reset armed", 0, 1, 0, 4'd6, 8'h00, 8'h00);
    step("R2 reset armed", 0, 1, 0, 4'd6, 8'h0F, 8'h0F);
    step("R2 first cycle", 1, 0, 0, 4'd1, 8'hA5, 8'hA5);
    check("R2 bit6 inverted", 32'(next_out), 32'hE5);
    step("R2 then done", 1, 0, 1, 4'd1, 8'hA5, 8'hA5);
    check("R2 done high", 32'(upset_done), 32'd1);
    step("R10 reset idle", 0, 0, 0, 4'd0, 8'h12, 8'h34);
    step("R10 idle again", 1, 0, 0, 4'd0, 8'h12, 8'h34);
    check("R10 done cleared", 32'(upset_done), 32'd0);
    step("R6 arm out of range", 1, 0, 1, 4'd12, 8'hC3, 8'hC3);
    step("R6 no flip", 1, 0, 0, 4'd2, 8'hC3, 8'hC3);
    check("R6 unchanged", 32'(next_out), 32'hC3);
    step("R6 shot consumed", 1, 0, 1, 4'd2, 8'h9C, 8'h9C);
    check("R6 done high", 32'(upset_done), 32'd1);
    step("R10 reset idle", 0, 0, 0, 4'd0, 8'h00, 8'h00);
    step("R10 arm sel0", 1, 0, 1, 4'd0, 8'hFE, 8'h01);
    step("R4 bit0 flip", 1, 0, 0, 4'd7, 8'hFE, 8'h00);
    check("R4 bit0 from cur", 32'(next_out), 32'hFF);
    step("R9 after flip", 1, 0, 0, 4'd7, 8'h44, 8'h00);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule